// File: doc/BRIEF.md
# Serial Two's Complementer

This block negates a binary word that moves through it one bit per clock, least significant bit first. Each output bit leaves in the same cycle as the input bit it belongs to, so the block adds no latency to the serial stream. It holds no copy of the word and contains no adder. A two-state Mealy sequencer does the work, helped by a small bit counter that marks where each word ends.

The sequencer starts a word in state SEEK. In SEEK each bit is passed through unchanged. The transition SEEK->FLIP happens on the first 1 bit, and that 1 bit is itself passed through unchanged. In state FLIP every later bit of the word is inverted, and the self-transition FLIP->FLIP holds until the word ends. There are two ways back to SEEK. The transition END->SEEK happens after the last bit of a word. The transition START->SEEK happens whenever `word_start` marks a bit as the first of a new word; that bit is then handled as a SEEK bit whatever the stored state was. The transition SEEK->SEEK covers a 0 bit in SEEK. Cycles where `bit_valid` is low are idle and leave the sequencer and the counter as they were.

Top module: `serial_negator`

## Requirements
- R1: After reset the sequencer is in SEEK with the bit count at zero, so the first valid bit after reset comes out equal to the input bit even without `word_start`.
- R2: In SEEK (stored state SEEK, or any bit with `word_start` high) `bit_out` equals `bit_in` in the same cycle.
- R3: A valid bit of value 1 handled in SEEK moves the sequencer to FLIP for the next bit of the same word; a valid 0 in SEEK keeps it in SEEK.
- R4: In FLIP, for a valid bit without `word_start`, `bit_out` is the inverse of `bit_in`, and the sequencer stays in FLIP until the word ends.
- R5: After WIDTH valid bits (default 8) the sequencer returns to SEEK and the count to zero, so back-to-back words need no `word_start`.
- R6: `word_start` high on a valid bit restarts the word at bit position 0 in SEEK, discarding any partly processed word.
- R7: A cycle with `bit_valid` low changes neither the state nor the bit count, so idle gaps inside a word leave the result unchanged.
- R8: For every 8-bit input word w sent LSB first, the output bits, collected LSB first, form (~w + 1) mod 256.
- R9: The two words that are their own negation map to themselves: 0x00 gives 0x00 and 0x80 gives 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state and count update on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid | input | 1 | Marks that `bit_in` carries a bit in this cycle |
| word_start | input | 1 | Marks the valid bit as bit 0 of a new word |
| bit_in | input | 1 | Serial input bit, least significant bit first |
| bit_out | output | 1 | Serial negated bit, combinational from state and `bit_in` |

## Verification
A fixed table of words is sent first. It includes all zeros, the single low bit, the top bit alone, all ones and alternating patterns. Together these separate the pass-through phase from the invert phase, and they show whether the first 1 itself is inverted by mistake. All 256 words are then compared with the negation computed in the bench. Directed runs send words back to back without `word_start`, which shows whether the counter rearms the sequencer. They also restart a word partway through while the sequencer is in FLIP, and insert idle gaps between bits, which shows whether idle cycles move the state or the count.

// File: rtl/serial_negator_pkg.sv
package serial_negator_pkg;

    typedef enum logic {
        ST_SEEK = 1'b0,
        ST_FLIP = 1'b1
    } neg_state_e;

endpackage

// File: rtl/neg_bit_counter.sv
module neg_bit_counter #(
    parameter int WIDTH = 8,
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_valid,
    input  logic          word_start,
    output logic [CW-1:0] cnt_q,
    output logic          last_bit
);

    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    logic [CW-1:0] base_pos;
    logic [CW-1:0] cnt_d;

    // Position of the bit presented in this cycle
    always_comb begin
        base_pos = word_start ? '0 : cnt_q;
        last_bit = (base_pos == LAST);
    end

    always_comb begin
        cnt_d = cnt_q;
        if (bit_valid) begin
            if (last_bit) begin
                cnt_d = '0;
            end else begin
                cnt_d = base_pos + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/neg_sequencer.sv
module neg_sequencer
    import serial_negator_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_valid,
    input  logic       word_start,
    input  logic       bit_in,
    input  logic       last_bit,
    output neg_state_e state_q,
    output neg_state_e eff_state
);

    neg_state_e state_d;

    // A start bit is always handled as the first bit of a word
    always_comb begin
        eff_state = word_start ? ST_SEEK : state_q;
    end

    always_comb begin
        state_d = state_q;
        if (bit_valid) begin
            if (last_bit) begin
                state_d = ST_SEEK;
            end else begin
                unique case (eff_state)
                    ST_SEEK: state_d = bit_in ? ST_FLIP : ST_SEEK;
                    ST_FLIP: state_d = ST_FLIP;
                    default: state_d = ST_SEEK;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEEK;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/neg_output.sv
module neg_output
    import serial_negator_pkg::*;
(
    input  neg_state_e eff_state,
    input  logic       bit_in,
    output logic       bit_out
);

    always_comb begin
        unique case (eff_state)
            ST_SEEK: bit_out = bit_in;
            ST_FLIP: bit_out = ~bit_in;
            default: bit_out = bit_in;
        endcase
    end

endmodule

// File: rtl/serial_negator.sv
module serial_negator
    import serial_negator_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic word_start,
    input  logic bit_in,
    output logic bit_out
);

    neg_state_e    state_q;
    neg_state_e    eff_state;
    logic [CW-1:0] cnt_q;
    logic          last_bit;

    neg_bit_counter #(
        .WIDTH (WIDTH)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_valid  (bit_valid),
        .word_start (word_start),
        .cnt_q      (cnt_q),
        .last_bit   (last_bit)
    );

    neg_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_valid  (bit_valid),
        .word_start (word_start),
        .bit_in     (bit_in),
        .last_bit   (last_bit),
        .state_q    (state_q),
        .eff_state  (eff_state)
    );

    neg_output u_out (
        .eff_state (eff_state),
        .bit_in    (bit_in),
        .bit_out   (bit_out)
    );

endmodule

// File: rtl/serial_negator_chk.sv
module serial_negator_chk
    import serial_negator_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_valid,
    input logic          word_start,
    input logic          bit_in,
    input logic          bit_out,
    input neg_state_e    state_q,
    input logic [CW-1:0] cnt_q
);

    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    // R2
    seek_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && (word_start || state_q == ST_SEEK)) |-> (bit_out == bit_in));

    // R4
    flip_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && !word_start && state_q == ST_FLIP) |-> (bit_out != bit_in));

    // R3
    seek_to_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && (word_start || state_q == ST_SEEK) && bit_in
         && !(!word_start && cnt_q == LAST)) |=> (state_q == ST_FLIP));

    // R5
    word_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && !word_start && cnt_q == LAST) |=> (state_q == ST_SEEK && cnt_q == '0));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> ($stable(state_q) && $stable(cnt_q)));

    // R6
    restart_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && word_start) |=> (cnt_q == CW'(1)));

endmodule

bind serial_negator serial_negator_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (bit_valid),
    .word_start (word_start),
    .bit_in     (bit_in),
    .bit_out    (bit_out),
    .state_q    (state_q),
    .cnt_q      (cnt_q)
);

// File: tb/serial_negator_tb.sv
module serial_negator_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {input word, expected output word}
    localparam logic [15:0] VECS [NVEC] = '{
        16'h00_00, 16'h01_FF, 16'h80_80, 16'hFF_01,
        16'h02_FE, 16'h55_AB, 16'hA0_60, 16'h7F_81
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 1'b0;
    logic word_start = 1'b0;
    logic bit_in = 1'b0;
    logic bit_out;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_negator u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_valid  (bit_valid),
        .word_start (word_start),
        .bit_in     (bit_in),
        .bit_out    (bit_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Drive one bit at the falling edge, sample the Mealy output just after
    task automatic send_bit(input logic b, input logic st, output logic o);
        @(negedge clk);
        bit_valid  = 1'b1;
        word_start = st;
        bit_in     = b;
        #1 o = bit_out;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        bit_valid  = 1'b0;
        word_start = 1'b0;
        bit_in     = 1'b1;
    endtask

    task automatic send_word(input logic [7:0] w, input logic st, input logic gap,
                             output logic [7:0] got);
        logic o;
        for (int i = 0; i < 8; i++) begin
            send_bit(w[i], st && (i == 0), o);
            got[i] = o;
            if (gap) idle_cycle();
        end
        idle_cycle();
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] got;
        logic o;

        // R1: reset state seen at the port while reset is held
        bit_valid = 1'b1;
        bit_in    = 1'b1;
        #(CLK_PERIOD * 2 + 1);
        check("R1 reset output follows input", {7'd0, bit_out}, 8'h01);
        @(negedge clk);
        rst_n     = 1'b1;
        bit_valid = 1'b0;

        // R1: first word after reset without word_start
        send_word(8'h04, 1'b0, 1'b0, got);
        check("R1 first word after reset", got, 8'hFC);

        // R8 R9: table walk
        for (int k = 0; k < NVEC; k++) begin
            send_word(VECS[k][15:8], 1'b1, 1'b0, got);
            check("R8 R9 table word", got, VECS[k][7:0]);
        end

        // R8: exhaustive sweep
        for (int w = 0; w < 256; w++) begin
            send_word(8'(w), 1'b1, 1'b0, got);
            check("R8 sweep", got, 8'((~w) + 1));
        end

        // R2 R3 R4: bit by bit in word 0x14
        send_bit(1'b0, 1'b1, o); check("R2 seek 0 passes", {7'd0, o}, 8'h00);
        send_bit(1'b0, 1'b0, o); check("R3 stay seek on 0", {7'd0, o}, 8'h00);
        send_bit(1'b1, 1'b0, o); check("R2 first 1 passes", {7'd0, o}, 8'h01);
        send_bit(1'b0, 1'b0, o); check("R3 R4 flip after 1", {7'd0, o}, 8'h01);
        send_bit(1'b1, 1'b0, o); check("R4 flip 1 inverted", {7'd0, o}, 8'h00);
        send_bit(1'b0, 1'b0, o); check("R4 stays flip", {7'd0, o}, 8'h01);
        send_bit(1'b0, 1'b0, o);
        send_bit(1'b0, 1'b0, o); check("R4 last bit flipped", {7'd0, o}, 8'h01);
        idle_cycle();

        // R5: back-to-back words, start only on the first
        send_word(8'h01, 1'b1, 1'b0, got);
        check("R5 first of pair", got, 8'hFF);
        send_word(8'h01, 1'b0, 1'b0, got);
        check("R5 second word rearmed", got, 8'hFF);
        send_word(8'h80, 1'b0, 1'b0, got);
        check("R5 R9 third word", got, 8'h80);

        // R6: restart mid-word while in FLIP
        send_bit(1'b1, 1'b1, o);
        send_bit(1'b0, 1'b0, o);
        send_bit(1'b0, 1'b0, o);
        send_word(8'h04, 1'b1, 1'b0, got);
        check("R6 restart discards partial word", got, 8'hFC);
        send_word(8'h02, 1'b0, 1'b0, got);
        check("R6 count restarted at zero", got, 8'hFE);

        // R7: idle gaps after every bit
        send_word(8'h06, 1'b1, 1'b1, got);
        check("R7 gaps keep result", got, 8'hFA);
        send_word(8'h00, 1'b0, 1'b1, got);
        check("R7 count held through gaps", got, 8'h00);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule